// File: doc/BRIEF.md
# Processor Doze Mode Sequencer

This block moves a processor core between normal execution and a light power-down state called doze. Software arms doze by setting two control bits, a machine-state wait-enable and a doze-enable. An outside master can also request doze directly. When either arming condition holds and no interrupt is pending, the sequencer halts instruction issue. It waits for the core to report that it is quiescent and then settles in doze. While dozing, the core still answers data cache snoops. Its time base keeps counting and can raise a periodic interrupt.

Any interrupt that reaches the core in doze starts a wake handshake. The sequencer raises a wake request and holds it until the core acknowledges. Execution resumes on the following cycle. After the interrupt is serviced and the pending line drops, the sequencer slides back into doze on its own if the arming bits are still set. To stay awake, software must clear those bits. The two status outputs, asleep and ready, are both held low throughout doze and during the transitions. Four one-hot debug outputs show which state the sequencer is in.

Top module: `doze_seq`

## Requirements
- R1: After reset the sequencer is in the run state. ready_o is 1. halt_o, wake_req_o, asleep_o and snoop_ack_o are 0.
- R2: In run, the sequencer moves to the entering state on the next clock edge only if wait_en_i and doze_en_i are both 1 (or R12 applies) and irq_i is 0. Either bit alone leaves it in run.
- R3: In the entering state halt_o is 1. The state becomes doze on the clock edge at which core_idle_i is 1.
- R4: An interrupt seen in the entering state returns the sequencer to run on the next edge, even when core_idle_i is 1 in that same cycle.
- R5: In doze halt_o is 1. The sequencer stays in doze while no interrupt is pending, even if the arming bits are cleared.
- R6: An interrupt in doze moves the sequencer to the wake state on the next edge. wake_req_o is 1 only in the wake state and stays 1 until wake_ack_i is seen. The edge that samples wake_ack_i at 1 returns the sequencer to run.
- R7: Back in run, once irq_i is 0, the sequencer re-enters doze if the arming bits are still set. With wait_en_i cleared it stays in run.
- R8: snoop_ack_o equals snoop_req_i delayed by one clock, in every state.
- R9: While tb_en_i is 1 the time base counts in every state. tb_irq_o is 1 during the last count of each TB_PERIOD-cycle period, which is TB_PERIOD-1 edges after enabling from reset. A tb_irq_o pulse acts as an interrupt and wakes the core from doze.
- R10: asleep_o is always 0. ready_o is 1 exactly when the state is run.
- R11: Exactly one of st_run_o, st_enter_o, st_doze_o and st_wake_o is 1 in every cycle.
- R12: ext_doze_req_i at 1 arms doze on its own, with the same effect as both software bits being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_en_i | input | 1 | Machine-state wait-enable bit |
| doze_en_i | input | 1 | Doze-enable control bit |
| ext_doze_req_i | input | 1 | Doze request from an external master register |
| irq_i | input | 1 | Interrupt pending at the core |
| core_idle_i | input | 1 | Core reports instruction issue has drained |
| wake_ack_i | input | 1 | Core acknowledges the wake request |
| snoop_req_i | input | 1 | Data cache snoop request |
| tb_en_i | input | 1 | Time base count enable |
| halt_o | output | 1 | Suspend instruction issue |
| wake_req_o | output | 1 | Wake request to the core |
| snoop_ack_o | output | 1 | Snoop serviced |
| tb_irq_o | output | 1 | Time base interrupt pulse |
| asleep_o | output | 1 | Asleep status (low in doze) |
| ready_o | output | 1 | Ready status (low outside run) |
| st_run_o | output | 1 | Debug: run state |
| st_enter_o | output | 1 | Debug: entering doze |
| st_doze_o | output | 1 | Debug: doze |
| st_wake_o | output | 1 | Debug: wake handshake |

## Verification
On every cycle, the assertions check the following. The state outputs are one-hot and ready tracks run. Asleep never rises, and snoops are answered one cycle later. An interrupt aborts entry or wakes the core on the next edge, and doze persists without one. The wake request is confined to the wake state and ends on acknowledge. Several behaviours are shown only by the bench's scenarios. These are the gating by both arming bits, the automatic re-entry after service versus staying awake once a bit is cleared, the external request path, and the exact time base period that wakes a dozing core.

// File: rtl/doze_pkg.sv
package doze_pkg;
  typedef enum logic [1:0] {
    DZ_RUN   = 2'd0,
    DZ_ENTER = 2'd1,
    DZ_DOZE  = 2'd2,
    DZ_WAKE  = 2'd3
  } dz_state_e;

  // Doze is armed by both software bits together, or by the outside master.
  function automatic logic doze_armed(input logic wait_en, input logic doze_en,
                                      input logic ext_req);
    return (wait_en & doze_en) | ext_req;
  endfunction

  // Time base reaches its final count of a period.
  function automatic logic tb_at_end(input int unsigned cnt, input int unsigned period);
    return cnt == period - 1;
  endfunction
endpackage

// File: rtl/doze_fsm.sv
module doze_fsm
  import doze_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      armed,
  input  logic      irq_any,
  input  logic      core_idle,
  input  logic      wake_ack,
  output dz_state_e state
);
  dz_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      DZ_RUN:   if (armed && !irq_any) nxt = DZ_ENTER;
      DZ_ENTER: begin
        if (irq_any || !armed) nxt = DZ_RUN;
        else if (core_idle)    nxt = DZ_DOZE;
      end
      DZ_DOZE:  if (irq_any) nxt = DZ_WAKE;
      DZ_WAKE:  if (wake_ack) nxt = DZ_RUN;
      default:  nxt = DZ_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= DZ_RUN;
    else        state <= nxt;
  end
endmodule

// File: rtl/doze_timebase.sv
module doze_timebase
  import doze_pkg::*;
#(
  parameter int unsigned TB_PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tb_en,
  output logic tb_irq
);
  localparam int unsigned TBW = (TB_PERIOD > 2) ? $clog2(TB_PERIOD) : 1;
  localparam logic [TBW-1:0] LAST = TBW'(TB_PERIOD - 1);

  logic [TBW-1:0] cnt;
  logic           at_end;

  assign at_end = tb_at_end(int'(cnt), TB_PERIOD);
  assign tb_irq = tb_en & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (tb_en)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/doze_snoop.sv
module doze_snoop (
  input  logic clk,
  input  logic rst_n,
  input  logic snoop_req,
  output logic snoop_ack
);
  always_ff @(posedge clk) begin
    if (!rst_n) snoop_ack <= 1'b0;
    else        snoop_ack <= snoop_req;
  end
endmodule

// File: rtl/doze_seq.sv
module doze_seq
  import doze_pkg::*;
#(
  parameter int unsigned TB_PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_en_i,
  input  logic doze_en_i,
  input  logic ext_doze_req_i,
  input  logic irq_i,
  input  logic core_idle_i,
  input  logic wake_ack_i,
  input  logic snoop_req_i,
  input  logic tb_en_i,
  output logic halt_o,
  output logic wake_req_o,
  output logic snoop_ack_o,
  output logic tb_irq_o,
  output logic asleep_o,
  output logic ready_o,
  output logic st_run_o,
  output logic st_enter_o,
  output logic st_doze_o,
  output logic st_wake_o
);
  dz_state_e state;
  logic      armed;
  logic      irq_any;
  logic      tb_irq;

  assign armed   = doze_armed(wait_en_i, doze_en_i, ext_doze_req_i);
  assign irq_any = irq_i | tb_irq;

  doze_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (armed),
    .irq_any   (irq_any),
    .core_idle (core_idle_i),
    .wake_ack  (wake_ack_i),
    .state     (state)
  );

  doze_timebase #(.TB_PERIOD(TB_PERIOD)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .tb_en  (tb_en_i),
    .tb_irq (tb_irq)
  );

  doze_snoop u_snp (
    .clk       (clk),
    .rst_n     (rst_n),
    .snoop_req (snoop_req_i),
    .snoop_ack (snoop_ack_o)
  );

  assign st_run_o   = (state == DZ_RUN);
  assign st_enter_o = (state == DZ_ENTER);
  assign st_doze_o  = (state == DZ_DOZE);
  assign st_wake_o  = (state == DZ_WAKE);

  assign halt_o     = !st_run_o;
  assign wake_req_o = st_wake_o;
  assign ready_o    = st_run_o;
  assign asleep_o   = 1'b0;
  assign tb_irq_o   = tb_irq;
endmodule

// File: rtl/doze_seq_chk.sv
module doze_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic st_run,
  input logic st_enter,
  input logic st_doze,
  input logic st_wake,
  input logic ready,
  input logic asleep,
  input logic halt,
  input logic wake_req,
  input logic wake_ack,
  input logic irq_any,
  input logic snoop_req,
  input logic snoop_ack
);
  p_state_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({st_run, st_enter, st_doze, st_wake}));
  p_ready_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready == st_run);
  p_asleep_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !asleep);
  p_halt_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_enter |-> halt);
  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_enter && irq_any) |=> st_run);
  p_doze_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_doze && !irq_any) |=> (st_doze && halt));
  p_wake_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_doze && irq_any) |=> st_wake);
  p_wake_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> st_wake);
  p_wake_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wake && wake_ack) |=> st_run);
  p_snoop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_req |=> snoop_ack);
endmodule

bind doze_seq doze_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_run    (st_run_o),
  .st_enter  (st_enter_o),
  .st_doze   (st_doze_o),
  .st_wake   (st_wake_o),
  .ready     (ready_o),
  .asleep    (asleep_o),
  .halt      (halt_o),
  .wake_req  (wake_req_o),
  .wake_ack  (wake_ack_i),
  .irq_any   (irq_any),
  .snoop_req (snoop_req_i),
  .snoop_ack (snoop_ack_o)
);

// File: tb/doze_seq_tb.sv
module doze_seq_tb;
  localparam int unsigned P = 16;
  localparam logic [3:0] RUN = 4'b1000, ENT = 4'b0100, DOZ = 4'b0010, WAK = 4'b0001;

  logic clk = 1'b0;
  logic rst_n, wait_en, doze_en, ext_req, irq, idle, ack, snoop, tb_en;
  logic halt, wake_req, snoop_ack, tb_irq, asleep, ready;
  logic s_run, s_ent, s_doz, s_wak;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  doze_seq #(.TB_PERIOD(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .wait_en_i(wait_en), .doze_en_i(doze_en),
    .ext_doze_req_i(ext_req), .irq_i(irq), .core_idle_i(idle),
    .wake_ack_i(ack), .snoop_req_i(snoop), .tb_en_i(tb_en),
    .halt_o(halt), .wake_req_o(wake_req), .snoop_ack_o(snoop_ack),
    .tb_irq_o(tb_irq), .asleep_o(asleep), .ready_o(ready),
    .st_run_o(s_run), .st_enter_o(s_ent), .st_doze_o(s_doz), .st_wake_o(s_wak)
  );

  function automatic logic armed_ref(logic w, logic d, logic e);
    return e | (w & d);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_st(string req, logic [3:0] exp);
    chk(req, {s_run, s_ent, s_doz, s_wak}, exp);
    chk({req, "/R11"}, 32'($countones({s_run, s_ent, s_doz, s_wak})), 1);
    chk({req, "/R10"}, {ready, asleep}, {exp == RUN, 1'b0});
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    {wait_en, doze_en, ext_req, irq, idle, ack, snoop, tb_en} = '0;
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic go_doze();
    wait_en = 1; doze_en = 1; idle = 1;
    step(2);
  endtask

  task automatic t_reset();
    do_reset();
    chk_st("R1 state", RUN);
    chk("R1 outputs", {halt, wake_req, asleep, snoop_ack}, 4'b0000);
  endtask

  task automatic t_gating();
    do_reset();
    wait_en = 1; step(3); chk_st("R2 wait only", RUN);
    wait_en = 0; doze_en = 1; step(3); chk_st("R2 doze only", RUN);
    wait_en = 1; irq = 1; step(2); chk_st("R2 irq blocks", RUN);
    irq = 0; step(); chk_st("R2 entry", ENT);
  endtask

  task automatic t_doze_wake();
    do_reset();
    wait_en = 1; doze_en = 1; step();
    chk_st("R3 enter", ENT); chk("R3 halt", halt, 1);
    step(2); chk_st("R3 waits idle", ENT);
    idle = 1; step(); chk_st("R3 doze", DOZ); chk("R5 halt", halt, 1);
    doze_en = 0; step(3); chk_st("R5 hold", DOZ);
    doze_en = 1; irq = 1; step();
    chk_st("R6 wake", WAK); chk("R6 wake_req", wake_req, 1);
    irq = 0; step(3); chk_st("R6 wait ack", WAK); chk("R6 wake_req held", wake_req, 1);
    ack = 1; step(); ack = 0;
    chk_st("R6 run", RUN); chk("R6 req low", wake_req, 0);
    step(); chk_st("R7 reenter", ENT);
    step(); chk_st("R7 doze again", DOZ);
    irq = 1; step(); ack = 1; step(); ack = 0; chk_st("R7 woken", RUN);
    irq = 0; wait_en = 0; step(4); chk_st("R7 stays run", RUN);
    chk("R7 armed ref", armed_ref(wait_en, doze_en, ext_req), 0);
  endtask

  task automatic t_abort();
    do_reset();
    wait_en = 1; doze_en = 1; step(); chk_st("R4 entering", ENT);
    irq = 1; idle = 1; step(); chk_st("R4 abort", RUN);
  endtask

  task automatic t_ext();
    do_reset();
    ext_req = 1; step(); chk_st("R12 ext entry", ENT);
    idle = 1; step(); chk_st("R12 ext doze", DOZ);
  endtask

  task automatic t_snoop();
    do_reset();
    snoop = 1; step(); chk("R8 run ack", snoop_ack, 1);
    snoop = 0; step(); chk("R8 run drop", snoop_ack, 0);
    go_doze(); chk_st("R8 in doze", DOZ);
    snoop = 1; step(); chk("R8 doze ack", snoop_ack, 1);
    snoop = 0; step(); chk("R8 doze drop", snoop_ack, 0);
  endtask

  task automatic t_timer();
    int edges = 0;
    do_reset();
    go_doze(); chk_st("R9 doze", DOZ);
    tb_en = 1;
    while (!tb_irq && edges < 4 * P) begin
      step(); edges++;
    end
    chk("R9 period", edges, P - 1);
    chk_st("R9 still doze", DOZ);
    step(); chk_st("R9 timer wakes", WAK);
    tb_en = 0; chk("R9 pulse ends", tb_irq, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_gating();
    t_doze_wake();
    t_abort();
    t_ext();
    t_snoop();
    t_timer();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule